// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Lookup and Replacement Unit

This unit sits between a requester and a simple word-per-block backing memory. A request names a block number; the low bits of that number select a set and the remaining bits form a tag. Each set has two ways. Each way holds a valid flag, a dirty flag, a tag and one data word. Both ways of the selected set are compared at once. A hit completes without touching memory. A read hit returns the stored word. A write hit replaces the stored word and marks the line dirty.

On a miss the unit picks a victim. An empty way in the set is always taken before an occupied one. When both ways are occupied, a per-set least-recently-used bit names the victim. If the victim is dirty, the unit first writes it back to memory and then reads the requested block. The new line is installed clean, and the request is then replayed as a hit. A write miss therefore ends with the new line dirty and holding the written word. The requester sees one completion pulse per request, with a flag that tells a hit from a miss.

Top module: `lru2_cache`

## Requirements
- R1: Block number b maps to set b mod SETS and carries tag b / SETS. With the default 64 sets, blocks 0, 64, 128 and so on up to 448 compete for set 0, while blocks in other sets never disturb it.
- R2: A request is accepted on a clock edge where `cpu_req` and `cpu_ready` are both high. On a hit, `cpu_done` pulses for exactly one cycle, starting after the second rising edge from acceptance. With the pulse, `cpu_hit`=1 and `cpu_rdata` is the stored word; no memory transaction takes place.
- R3: A write hit stores `cpu_wdata` in the line, returns it on `cpu_rdata` and marks the line dirty. A later eviction of that line writes the word back.
- R4: On a miss, an invalid way of the set is filled before any valid way is replaced. Way 0 is taken when both ways are invalid.
- R5: Every hit and every fill sets the set's LRU bit to the way not just used. A miss in a full set replaces the way that LRU bit names.
- R6: A victim that is valid and dirty is written to memory at block address {victim tag, set} with its data, before the refill read. A clean victim causes only the refill read. A miss thus costs one memory transaction when the victim is clean and two when it is dirty.
- R7: A refilled line is installed valid and clean with the word read from memory. The request then completes with `cpu_hit`=0. A write miss leaves the line dirty and holding `cpu_wdata`.
- R8: Reset (synchronous, active high) clears every valid, dirty and LRU bit. After reset every access misses, and no dirty data from before reset is written back. After reset `cpu_ready`=1, `cpu_done`=0 and `mem_req`=0.
- R9: `mem_req` stays high, with `mem_addr` and `mem_we` unchanged, until `mem_ack` is seen. `mem_we`=1 marks a write-back, and `mem_we`=0 marks a refill read whose data arrives on `mem_rdata` in the `mem_ack` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W (9) | Block number |
| cpu_wdata | input | DATA_W (32) | Write word |
| cpu_ready | output | 1 | Unit idle and able to accept |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request hit without memory traffic (valid with `cpu_done`) |
| cpu_rdata | output | DATA_W (32) | Line word after the request (valid with `cpu_done`) |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | ADDR_W (9) | Memory block number |
| mem_wdata | output | DATA_W (32) | Write-back word |
| mem_ack | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | DATA_W (32) | Refill word, valid with `mem_ack` |

## Verification
The hardest case to reach is a dirty line that has become least recently used in a full set. Reaching it needs a fill of both ways, then a write hit, then a touch of the other way, and finally a third conflicting block. The directed phase builds this order inside set 0 and then reads the evicted block back, so that the write-back must land in memory before the refill. A seeded pseudo-random phase then works on four sets with eight tags each. This keeps conflict misses, dirty evictions and LRU flips frequent, and a reset in the middle of the run checks that dirty lines are dropped without a write-back.

// File: rtl/lru2_pkg.sv
package lru2_pkg;

    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WB,
        ST_FILL
    } ctl_state_e;

    // Free way first (way 0 before way 1), otherwise the LRU pointer.
    function automatic logic pick_way(input logic [WAYS-1:0] vld, input logic lru);
        if (!vld[0])      return 1'b0;
        else if (!vld[1]) return 1'b1;
        else              return lru;
    endfunction

endpackage

// File: rtl/lru2_arrays.sv
module lru2_arrays
    import lru2_pkg::*;
#(
    parameter int SETS   = 64,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [IDX_W-1:0]             idx,
    output logic [WAYS-1:0]              rd_valid,
    output logic [WAYS-1:0]              rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_data,
    output logic                         rd_lru,
    input  logic                         wr_en,
    input  logic                         wr_way,
    input  logic                         wr_dirty,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         lru_en,
    input  logic                         lru_way
);
    logic [WAYS-1:0]   vld_q [SETS];
    logic [WAYS-1:0]   drt_q [SETS];
    logic              lru_q [SETS];
    logic [TAG_W-1:0]  tag_q [SETS][WAYS];
    logic [DATA_W-1:0] dat_q [SETS][WAYS];

    // State bits: cleared by reset (R8)
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                drt_q[s] <= '0;
                lru_q[s] <= 1'b0;
            end
        end else begin
            if (wr_en) begin
                vld_q[idx][wr_way] <= 1'b1;
                drt_q[idx][wr_way] <= wr_dirty;
            end
            if (lru_en) lru_q[idx] <= lru_way;
        end
    end

    // Payload: no reset needed, guarded by valid
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx][wr_way] <= wr_tag;
            dat_q[idx][wr_way] <= wr_data;
        end
    end

    assign rd_valid = vld_q[idx];
    assign rd_dirty = drt_q[idx];
    assign rd_lru   = lru_q[idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tag[w]  = tag_q[idx][w];
        assign rd_data[w] = dat_q[idx][w];
    end

endmodule

// File: rtl/lru2_match.sv
module lru2_match
    import lru2_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       hit_any,
    output logic                       hit_way
);
    logic [WAYS-1:0] hv;

    // Parallel compare of every way in the set
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hv[w] = valid[w] && (tags[w] == req_tag);
    end

    assign hit_any = |hv;
    assign hit_way = hv[1];

endmodule

// File: rtl/lru2_victim.sv
module lru2_victim
    import lru2_pkg::*;
(
    input  logic [WAYS-1:0] valid,
    input  logic [WAYS-1:0] dirty,
    input  logic            lru,
    output logic            way,
    output logic            needs_wb
);
    assign way      = pick_way(valid, lru);
    assign needs_wb = valid[way] && dirty[way];
endmodule

// File: rtl/lru2_cache.sv
module lru2_cache
    import lru2_pkg::*;
#(
    parameter int SETS   = 64,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    ctl_state_e st;
    req_t       rq;
    logic       missed, vic_q;
    logic       done_q, hit_q;
    logic [DATA_W-1:0] rdata_q;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    assign idx = rq.addr[IDX_W-1:0];
    assign tag = rq.addr[ADDR_W-1:IDX_W];

    logic [WAYS-1:0]             rd_valid, rd_dirty;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0][DATA_W-1:0] rd_data;
    logic                        rd_lru;
    logic                        hit_any, hit_way, vic_way, vic_wb;

    logic              wr_en, wr_way, wr_dirty, lru_en, lru_way;
    logic [DATA_W-1:0] wr_data;

    lru2_arrays #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_arrays (
        .clk(clk), .rst(rst), .idx(idx),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
        .rd_data(rd_data), .rd_lru(rd_lru),
        .wr_en(wr_en), .wr_way(wr_way), .wr_dirty(wr_dirty),
        .wr_tag(tag), .wr_data(wr_data),
        .lru_en(lru_en), .lru_way(lru_way)
    );

    lru2_match #(.TAG_W(TAG_W)) u_match (
        .valid(rd_valid), .tags(rd_tag), .req_tag(tag),
        .hit_any(hit_any), .hit_way(hit_way)
    );

    lru2_victim u_victim (
        .valid(rd_valid), .dirty(rd_dirty), .lru(rd_lru),
        .way(vic_way), .needs_wb(vic_wb)
    );

    // Array writes and memory port
    always_comb begin
        wr_en     = 1'b0;
        wr_way    = hit_way;
        wr_dirty  = 1'b0;
        wr_data   = rq.wdata;
        lru_en    = 1'b0;
        lru_way   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = rq.addr;
        mem_wdata = rd_data[vic_q];
        unique case (st)
            ST_LOOK: if (hit_any) begin
                lru_en  = 1'b1;
                lru_way = ~hit_way;
                if (rq.we) begin
                    wr_en    = 1'b1;
                    wr_dirty = 1'b1;
                end
            end
            ST_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {rd_tag[vic_q], idx};
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    wr_en   = 1'b1;
                    wr_way  = vic_q;
                    wr_data = mem_rdata;
                    lru_en  = 1'b1;
                    lru_way = ~vic_q;
                end
            end
            default: ;
        endcase
    end

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            rq      <= '0;
            missed  <= 1'b0;
            vic_q   <= 1'b0;
            done_q  <= 1'b0;
            hit_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: if (cpu_req) begin
                    rq     <= '{we: cpu_we, addr: cpu_addr, wdata: cpu_wdata};
                    missed <= 1'b0;
                    st     <= ST_LOOK;
                end
                ST_LOOK: if (hit_any) begin
                    done_q  <= 1'b1;
                    hit_q   <= ~missed;
                    rdata_q <= rq.we ? rq.wdata : rd_data[hit_way];
                    st      <= ST_IDLE;
                end else begin
                    missed <= 1'b1;
                    vic_q  <= vic_way;
                    st     <= vic_wb ? ST_WB : ST_FILL;
                end
                ST_WB:   if (mem_ack) st <= ST_FILL;
                ST_FILL: if (mem_ack) st <= ST_LOOK;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready = (st == ST_IDLE);
    assign cpu_done  = done_q;
    assign cpu_hit   = hit_q;
    assign cpu_rdata = rdata_q;

    // R2: completion is a single-cycle pulse and leaves the unit idle
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done && cpu_ready);

    // R4: a free way is chosen ahead of any occupied way
    a_r4_free_first: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOOK && !hit_any && rd_valid != 2'b11) |-> !rd_valid[vic_way]);

    // R5: full set replaces the way the LRU bit names
    a_r5_lru_victim: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOOK && !hit_any && rd_valid == 2'b11) |-> vic_way == rd_lru);

    // R5: a hit leaves the LRU bit pointing at the other way
    a_r5_hit_flips: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOOK && hit_any) |=> rd_lru == ~$past(hit_way));

    // R6: write-back is followed by the refill read
    a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WB && mem_ack) |=> st == ST_FILL && mem_req && !mem_we);

    // R7: refilled line hits in the chosen way, clean
    a_r7_fill_clean: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FILL && mem_ack) |=>
            st == ST_LOOK && hit_any && hit_way == $past(vic_q) && !rd_dirty[$past(vic_q)]);

    // R9: memory request held steady until acknowledged
    a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

endmodule

// File: tb/lru2_cache_bench.sv
module lru2_cache_bench;
    localparam int SETS = 64, ADDR_W = 9, DATA_W = 32, BLKS = 512;

    logic clk = 1'b0, rst = 1'b1;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_ready, cpu_done, cpu_hit;
    logic [DATA_W-1:0] cpu_rdata;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata = '0;

    always #2ns clk = ~clk;   // 250 MHz

    lru2_cache #(.SETS(SETS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lru2_cache (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int total = 0, fails = 0;

    task automatic check(input bit ok, input string what, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    // Backing memory (device side) and golden memory (model side)
    logic [DATA_W-1:0] mem [BLKS];
    logic [DATA_W-1:0] gm  [BLKS];

    initial begin
        for (int i = 0; i < BLKS; i++) begin
            mem[i] = (i * 32'h0101_0101) ^ 32'hA500_0000;
            gm[i]  = mem[i];
        end
        forever begin
            @(posedge clk);
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr];
                if (mem_we) mem[mem_addr] <= mem_wdata;
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    // Reference model of the cache state
    bit              mv [SETS][2];
    bit              md [SETS][2];
    int              mt [SETS][2];
    logic [DATA_W-1:0] mdat [SETS][2];
    bit              ml [SETS];

    typedef struct {
        bit                hit;
        logic [DATA_W-1:0] rdata;
        int                nmem;
        string             rq;
    } exp_t;

    exp_t exq[$];
    logic [ADDR_W+DATA_W-1:0] wbq[$];

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            ml[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                mv[s][w] = 1'b0;
                md[s][w] = 1'b0;
            end
        end
    endtask

    task automatic access(input int a, input bit we, input logic [DATA_W-1:0] wd, input string rq);
        exp_t e;
        int idx, tg, hw, v, va;
        idx = a % SETS;
        tg  = a / SETS;
        hw  = -1;
        for (int w = 0; w < 2; w++)
            if (mv[idx][w] && mt[idx][w] == tg) hw = w;
        e.rq = rq;
        if (hw >= 0) begin
            e.hit  = 1'b1;
            e.nmem = 0;
        end else begin
            e.hit = 1'b0;
            v = !mv[idx][0] ? 0 : (!mv[idx][1] ? 1 : int'(ml[idx]));
            if (mv[idx][v] && md[idx][v]) begin
                va = mt[idx][v] * SETS + idx;
                wbq.push_back({va[ADDR_W-1:0], mdat[idx][v]});
                gm[va] = mdat[idx][v];
                e.nmem = 2;
            end else begin
                e.nmem = 1;
            end
            mv[idx][v]   = 1'b1;
            md[idx][v]   = 1'b0;
            mt[idx][v]   = tg;
            mdat[idx][v] = gm[a];
            hw = v;
        end
        if (we) begin
            mdat[idx][hw] = wd;
            md[idx][hw]   = 1'b1;
        end
        ml[idx] = (hw == 0);
        e.rdata = mdat[idx][hw];
        exq.push_back(e);

        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a[ADDR_W-1:0];
        cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_done) @(negedge clk);
    endtask

    // Monitor: completions, write-backs, request stability
    int nmem_seen = 0;
    bit prev_req = 1'b0;
    logic [ADDR_W-1:0] held_addr;

    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !prev_req) held_addr = mem_addr;
            if (mem_req && mem_ack) begin
                nmem_seen++;
                check(mem_addr == held_addr, "R9 address held until ack", 64'(mem_addr), 64'(held_addr));
                if (mem_we) begin
                    if (wbq.size() == 0) begin
                        check(1'b0, "R6 unexpected write-back", 64'(mem_addr), 64'hFFFF);
                    end else begin
                        logic [ADDR_W+DATA_W-1:0] w;
                        w = wbq.pop_front();
                        check({mem_addr, mem_wdata} == w, "R6 write-back address/data",
                              64'({mem_addr, mem_wdata}), 64'(w));
                    end
                end
            end
            prev_req = mem_req && !mem_ack;
            if (cpu_done) begin
                if (exq.size() == 0) begin
                    check(1'b0, "R2 unexpected completion", 64'(cpu_rdata), 64'hFFFF);
                end else begin
                    exp_t e;
                    e = exq.pop_front();
                    check(cpu_hit == e.hit, {e.rq, " hit flag"}, 64'(cpu_hit), 64'(e.hit));
                    check(cpu_rdata == e.rdata, {e.rq, " data"}, 64'(cpu_rdata), 64'(e.rdata));
                    check(nmem_seen == e.nmem, {e.rq, " memory transactions"},
                          64'(nmem_seen), 64'(e.nmem));
                end
                nmem_seen = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cpu_ready == 1'b1, "R8 ready after reset", 64'(cpu_ready), 64'd1);
        check(cpu_done == 1'b0, "R8 no completion after reset", 64'(cpu_done), 64'd0);
        check(mem_req == 1'b0, "R8 memory idle after reset", 64'(mem_req), 64'd0);

        // Directed: set 0 conflicts
        access(0,   1'b0, '0,           "R4 R1 first fill way0");
        access(64,  1'b0, '0,           "R4 second block fills free way1");
        access(0,   1'b0, '0,           "R2 read hit");
        access(0,   1'b1, 32'hDEAD0001, "R3 write hit marks dirty");
        access(128, 1'b0, '0,           "R5 clean LRU victim");
        access(192, 1'b0, '0,           "R6 dirty LRU victim written back");
        access(0,   1'b0, '0,           "R6 refill sees written-back word");
        access(256, 1'b1, 32'h5A5A0002, "R7 write miss");
        access(320, 1'b0, '0,           "R5 LRU after write miss");
        access(256, 1'b0, '0,           "R7 write-missed line hits dirty");
        access(448, 1'b0, '0,           "R1 block 448 in set 0");
        access(1,   1'b0, '0,           "R1 set 1 independent");
        access(65,  1'b1, 32'h0BAD0003, "R1 set 1 second way");
        access(1,   1'b0, '0,           "R2 set 1 hit");
        access(448, 1'b0, '0,           "R1 set 0 unaffected by set 1");

        // Reset with dirty lines present
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        access(65,  1'b0, '0,           "R8 dirty line dropped, miss after reset");
        access(448, 1'b0, '0,           "R8 miss after reset");

        // Pseudo-random over 4 sets x 8 tags
        lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            access(int'({lf[2:0], 4'b0000, lf[4:3]}), lf[7], {lf, ~lf}, "R5 R6 random mix");
        end

        repeat (4) @(negedge clk);
        check(wbq.size() == 0, "R6 all expected write-backs seen", 64'(wbq.size()), 64'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule